// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block times the interval between tachometer pulses from a set of fans, so that software can turn the figure into a rotation speed. Each channel has its own tach input, trigger bit and enable bit. The divider code, the edge selection and the window length are shared by all channels. A 0-to-1 change on a channel's trigger arms that channel. The channel then waits for a qualifying tach edge and counts divided tach-clock ticks until the next qualifying edge. It then posts a done flag and the tick count in a 32-bit result word.

The tick rate is the core clock divided by 4·4^d, where d is the divider code. Software computes speed as clk·60 / (2·count·ratio), and doubles the ratio when both edges are counted. A measurement has a limited window, counted in ticks from the trigger. If the measurement does not finish inside that window, the channel still posts done, with a saturated count, so software never waits forever.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset, every channel's result word is zero.
- R2: On an enabled channel, a trigger bit that was 0 and is now 1 starts a measurement, and one cycle later that channel's done flag and count are both zero. A trigger held at 1 does not start another measurement.
- R3: A tick occurs once every 4 << (2·d) clock cycles, where d is `div_sel_i`. The prescaler restarts when the channel is armed and again at the first qualifying edge.
- R4: With `edge_mode_i` = 2'b00, only rising tach edges qualify. The count is floor(D / ratio), where D is the number of clock cycles between two consecutive rising edges.
- R5: With `edge_mode_i` = 2'b01, only falling tach edges qualify, and the count is worked out as in R4.
- R6: With `edge_mode_i[1]` = 1 (values 2'b10 and 2'b11), edges of either polarity qualify, so a high phase of H cycles gives a count of floor(H / ratio).
- R7: In a channel's 32-bit result word, bit 31 is the done flag, bits 19:0 hold the count, and bits 30:20 read as zero.
- R8: If the U-th tick since the trigger arrives before the measurement is complete, the channel sets done with count 0xFFFFF. A U of 0 acts as 1. When no edge is seen, done appears 1 + U·ratio cycles after the trigger edge. When the first edge is seen at once, done appears 3 + U·ratio cycles after the trigger edge.
- R9: A channel whose enable is low ignores triggers, and its result does not change. Dropping the enable during a measurement abandons it without setting done. Raising the enable again does not restart the measurement.
- R10: Done becomes visible on the third rising clock edge after the tach transition that completes the measurement. This is two synchronizer flops plus the edge register.
- R11: Once done is set, the done flag and the count keep their values until the next accepted trigger, even while more tach edges arrive.
- R12: Channels are independent. A measurement on one channel never changes another channel's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the tach clock is divided from it |
| rst_n | input | 1 | Synchronous active-low reset |
| tach_i | input | NUM_CH | Asynchronous tach input, one bit per channel |
| trig_i | input | NUM_CH | Trigger bits; a 0-to-1 change starts a measurement |
| chan_en_i | input | NUM_CH | Channel enables |
| div_sel_i | input | DIV_W | Divider code d; ratio is 4 << (2·d) |
| edge_mode_i | input | 2 | 00 rising, 01 falling, 1x both edges |
| win_units_i | input | UNIT_W | Measurement window length in ticks |
| result_o | output | NUM_CH*32 | Per-channel result words: done in bit 31, count in bits 19:0 |

## Verification
Two cases are the hardest to reach from the ports. In the first, a prescaler tick and the completing edge land on the same clock edge. The bench reaches it by making the tach period an exact multiple of the ratio, and it also uses a period shorter than one ratio. In the second, the window expires after the prescaler has restarted at a first edge. The bench reaches it by raising the tach on the same cycle as the trigger and then holding it, so the expiry time moves by a known offset. Random periods, channels, divider codes and edge modes sit between these directed cases. For every run, the bench predicts both the count and the exact cycle on which done must rise.

// File: rtl/fan_tach_pkg.sv
// Package: shared types and field positions for the fan tach period meter.
// Assumes a 32-bit result word with the done flag in its top bit.
package fan_tach_pkg;

    localparam int unsigned RES_W         = 32;
    localparam int unsigned DONE_POS      = 31;
    localparam int unsigned MODE_FALL_BIT = 0;
    localparam int unsigned MODE_BOTH_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } chan_st_e;

endpackage

// File: rtl/fan_tach_sync.sv
// Two-flop synchronizer for one asynchronous tach input, followed by an
// edge register. Produces one-cycle rise and fall strobes. Assumes the
// tach input is slow compared with clk.
module fan_tach_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_i,
    output logic rise_o,
    output logic fall_o
);
    logic meta_q, sync_q, prev_q;

    // Synchronize the input and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= tach_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge strobes, one cycle wide.
    always_comb begin
        rise_o = sync_q & ~prev_q;
        fall_o = ~sync_q & prev_q;
    end
endmodule

// File: rtl/fan_tach_ticker.sv
// Tach-clock prescaler: gives one tick every 4 << (2*div_sel_i) cycles
// while run_i is high. clr_i restarts the phase, so the first tick comes
// one full ratio after the clear.
module fan_tach_ticker #(
    parameter int unsigned DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel_i,
    input  logic             clr_i,
    input  logic             run_i,
    output logic             tick_o
);
    localparam int unsigned MAX_SHIFT = 2 * ((1 << DIV_W) - 1);
    localparam int unsigned PRE_W     = 2 + MAX_SHIFT;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   ratio_m1;

    // Terminal count for the selected ratio, and the tick decode.
    always_comb begin
        ratio_m1 = ((PRE_W+1)'(4) << {div_sel_i, 1'b0}) - (PRE_W+1)'(1);
        tick_o   = run_i && ((PRE_W+1)'(pre_q) >= ratio_m1);
    end

    // Phase counter: cleared on restart, wraps on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pre_q <= '0;
        end else if (run_i) begin
            pre_q <= tick_o ? '0 : pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/fan_tach_chan.sv
// Measurement sequencer for one channel. A trigger rise arms the channel.
// The first qualifying edge starts counting ticks. The next qualifying
// edge posts done and the count. Window expiry posts done with an all-ones
// count. Assumes UNIT_W <= CNT_W, so the count cannot wrap inside a window.
module fan_tach_chan
    import fan_tach_pkg::*;
#(
    parameter int unsigned CNT_W  = 20,
    parameter int unsigned UNIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              en_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              tick_i,
    input  logic [1:0]        mode_i,
    input  logic [UNIT_W-1:0] units_i,
    output logic              pre_clr_o,
    output logic              pre_run_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  count_o
);
    chan_st_e          st_q;
    logic              trig_q;
    logic [UNIT_W-1:0] win_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              trig_rise, qual, win_hit;

    // Trigger edge, edge qualification, window expiry and prescaler control.
    always_comb begin
        trig_rise = trig_i & ~trig_q;
        if (mode_i[MODE_BOTH_BIT])      qual = rise_i | fall_i;
        else if (mode_i[MODE_FALL_BIT]) qual = fall_i;
        else                            qual = rise_i;
        win_hit   = tick_i &&
                    (((UNIT_W+1)'(win_q) + (UNIT_W+1)'(1)) >= (UNIT_W+1)'(units_i));
        pre_clr_o = en_i & (trig_rise | ((st_q == ST_ARMED) & qual));
        pre_run_o = (st_q != ST_IDLE);
    end

    // Trigger history, tracked whether or not the channel is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_i;
    end

    // Sequencer, window counter, tick counter and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            win_q   <= '0;
            cnt_q   <= '0;
            done_o  <= 1'b0;
            count_o <= '0;
        end else if (!en_i) begin
            st_q <= ST_IDLE;
        end else if (trig_rise) begin
            st_q    <= ST_ARMED;
            win_q   <= '0;
            cnt_q   <= '0;
            done_o  <= 1'b0;
            count_o <= '0;
        end else begin
            if ((st_q != ST_IDLE) && tick_i) win_q <= win_q + UNIT_W'(1);
            case (st_q)
                ST_ARMED: begin
                    if (qual) begin
                        st_q  <= ST_COUNT;
                        cnt_q <= '0;
                    end else if (win_hit) begin
                        st_q    <= ST_IDLE;
                        done_o  <= 1'b1;
                        count_o <= '1;
                    end
                end
                ST_COUNT: begin
                    if (qual) begin
                        st_q    <= ST_IDLE;
                        done_o  <= 1'b1;
                        count_o <= cnt_q + CNT_W'(tick_i);
                    end else if (win_hit) begin
                        st_q    <= ST_IDLE;
                        done_o  <= 1'b1;
                        count_o <= '1;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fan_tach_meter.sv
// Top level: one synchronizer, one prescaler and one sequencer per channel.
// The divider code, edge mode and window length are shared by all channels.
// Each channel's result word packs done (bit 31) and count (low CNT_W bits).
// Assumes CNT_W < 31 and UNIT_W <= CNT_W.
module fan_tach_meter
    import fan_tach_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DIV_W  = 2,
    parameter int unsigned UNIT_W = 16,
    parameter int unsigned CNT_W  = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       tach_i,
    input  logic [NUM_CH-1:0]       trig_i,
    input  logic [NUM_CH-1:0]       chan_en_i,
    input  logic [DIV_W-1:0]        div_sel_i,
    input  logic [1:0]              edge_mode_i,
    input  logic [UNIT_W-1:0]       win_units_i,
    output logic [NUM_CH*RES_W-1:0] result_o
);
    localparam int unsigned PAD_W = DONE_POS - CNT_W;

    logic [NUM_CH-1:0]       done_v;
    logic [NUM_CH*CNT_W-1:0] count_v;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic rise, fall, tick, pre_clr, pre_run;

        fan_tach_sync u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .tach_i (tach_i[g]),
            .rise_o (rise),
            .fall_o (fall)
        );

        fan_tach_ticker #(.DIV_W(DIV_W)) u_tick (
            .clk       (clk),
            .rst_n     (rst_n),
            .div_sel_i (div_sel_i),
            .clr_i     (pre_clr),
            .run_i     (pre_run),
            .tick_o    (tick)
        );

        fan_tach_chan #(.CNT_W(CNT_W), .UNIT_W(UNIT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig_i    (trig_i[g]),
            .en_i      (chan_en_i[g]),
            .rise_i    (rise),
            .fall_i    (fall),
            .tick_i    (tick),
            .mode_i    (edge_mode_i),
            .units_i   (win_units_i),
            .pre_clr_o (pre_clr),
            .pre_run_o (pre_run),
            .done_o    (done_v[g]),
            .count_o   (count_v[g*CNT_W +: CNT_W])
        );

        // Result word packing for this channel.
        assign result_o[g*RES_W +: RES_W] =
            {done_v[g], {PAD_W{1'b0}}, count_v[g*CNT_W +: CNT_W]};
    end
endmodule

// File: rtl/fan_tach_meter_chk.sv
// Assertion checker for fan_tach_meter, attached with bind. It watches the
// trigger and enable ports against each channel's done and count.
module fan_tach_meter_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 20
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       trig_i,
    input logic [NUM_CH-1:0]       chan_en_i,
    input logic [NUM_CH-1:0]       done_v,
    input logic [NUM_CH*CNT_W-1:0] count_v
);
    logic [NUM_CH-1:0] trig_prev;

    // Checker copy of the trigger history.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_prev <= '0;
        else        trig_prev <= trig_i;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R9: done can only rise on a cycle where the channel was enabled
        a_r9_done_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done_v[c]) |-> $past(chan_en_i[c]));

        // R2: an accepted trigger clears done and count one cycle later
        a_r2_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_en_i[c] && trig_i[c] && !trig_prev[c])
            |=> (!done_v[c] && (count_v[c*CNT_W +: CNT_W] == '0)));

        // R11: done stays set until a new trigger rise
        a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (done_v[c] && !(trig_i[c] && !trig_prev[c])) |=> done_v[c]);

        // R11: count stays put while done is held
        a_r11_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (done_v[c] && !(trig_i[c] && !trig_prev[c]))
            |=> $stable(count_v[c*CNT_W +: CNT_W]));
    end
endmodule

bind fan_tach_meter fan_tach_meter_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig_i),
    .chan_en_i (chan_en_i),
    .done_v    (done_v),
    .count_v   (count_v)
);

// File: tb/tb_fan_tach_meter.sv
// Self-checking bench: directed corner cases plus seeded random tach waveforms.
module tb_fan_tach_meter;
    localparam int NUM_CH = 4;
    localparam int DIV_W  = 2;
    localparam int UNIT_W = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NUM_CH-1:0]    tach = '0;
    logic [NUM_CH-1:0]    trig = '0;
    logic [NUM_CH-1:0]    en = '1;
    logic [DIV_W-1:0]     div_sel = '0;
    logic [1:0]           edge_mode = '0;
    logic [UNIT_W-1:0]    units = '1;
    logic [NUM_CH*32-1:0] result_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    fan_tach_meter #(.NUM_CH(NUM_CH), .DIV_W(DIV_W), .UNIT_W(UNIT_W), .CNT_W(20)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tach_i      (tach),
        .trig_i      (trig),
        .chan_en_i   (en),
        .div_sel_i   (div_sel),
        .edge_mode_i (edge_mode),
        .win_units_i (units),
        .result_o    (result_o)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] res(input int ch);
        return result_o[ch*32 +: 32];
    endfunction

    function automatic int ratio_of(input int d);
        return 4 << (2 * d);
    endfunction

    function automatic logic [31:0] exp_count(input int cycles, input int d);
        return 32'(cycles / ratio_of(d));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One measurement with a high phase hi, a low phase lo, then a second high phase.
    task automatic do_measure(input int ch, input int d, input int md, input int hi, input int lo);
        logic [31:0] snap [NUM_CH];
        logic [31:0] r;
        string tag;
        int first, cmpl, total;
        tag   = (md >= 2) ? "R6" : (md == 1) ? "R5" : "R4";
        first = (md == 1) ? hi : 0;
        cmpl  = (md >= 2) ? hi : (md == 1) ? 2*hi + lo : hi + lo;
        total = 2*hi + lo + 6;
        @(negedge clk);
        div_sel = DIV_W'(d); edge_mode = 2'(md); units = '1;
        tach[ch] = 1'b0; trig[ch] = 1'b0;
        repeat (4) @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) snap[c] = res(c);
        trig[ch] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 cleared after trigger", res(ch), 32'h0);
        for (int i = 0; i < total; i++) begin
            if (i == cmpl + 2) chk("R10 done not yet", 32'(res(ch) >> 31), 32'h0);
            if (i == cmpl + 3) begin
                r = res(ch);
                chk("R10 done rises", 32'(r >> 31), 32'h1);
                chk({tag, " R3 count"}, {12'h0, r[19:0]}, exp_count(cmpl - first, d));
                chk("R7 reserved bits", 32'(r[30:20]), 32'h0);
            end
            tach[ch] = (i < hi) ? 1'b1 : (i < hi + lo) ? 1'b0 : (i < 2*hi + lo) ? 1'b1 : 1'b0;
            @(negedge clk);
        end
        chk("R11 result held", res(ch), {1'b1, 11'h0, exp_count(cmpl - first, d)[19:0]});
        for (int c = 0; c < NUM_CH; c++)
            if (c != ch) chk("R12 other channel", res(c), snap[c]);
        trig[ch] = 1'b0;
    endtask

    // Window expiry, with or without a first edge at trigger time.
    task automatic do_timeout(input int ch, input int d, input int u, input bit with_edge);
        int tend, off;
        @(negedge clk);
        div_sel = DIV_W'(d); edge_mode = 2'b00; units = UNIT_W'(u);
        tach[ch] = 1'b0; trig[ch] = 1'b0;
        repeat (4) @(negedge clk);
        off  = with_edge ? 3 : 1;
        tend = ((u == 0) ? 1 : u) * ratio_of(d) + off;
        trig[ch] = 1'b1;
        if (with_edge) tach[ch] = 1'b1;
        for (int i = 0; i <= tend; i++) begin
            if (i == tend - 1) chk("R8 not expired yet", 32'(res(ch) >> 31), 32'h0);
            if (i == tend)     chk("R8 expiry result", res(ch), 32'h800F_FFFF);
            @(negedge clk);
        end
        trig[ch] = 1'b0; tach[ch] = 1'b0;
        units = '1;
    endtask

    // Disabled channel ignores triggers; disabling mid-run abandons it.
    task automatic do_disable(input int ch);
        logic [31:0] snap;
        @(negedge clk);
        div_sel = '0; edge_mode = 2'b00; units = '1; trig[ch] = 1'b0; tach[ch] = 1'b0;
        repeat (3) @(negedge clk);
        snap = res(ch);
        en[ch] = 1'b0;
        @(negedge clk); trig[ch] = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tach[ch] = ((i / 6) % 2) == 1;
            @(negedge clk);
        end
        chk("R9 trigger ignored while disabled", res(ch), snap);
        trig[ch] = 1'b0; tach[ch] = 1'b0; en[ch] = 1'b1;
        repeat (4) @(negedge clk);
        trig[ch] = 1'b1;
        repeat (3) @(negedge clk);
        tach[ch] = 1'b1;
        repeat (6) @(negedge clk);
        en[ch] = 1'b0;
        tach[ch] = 1'b0;
        repeat (6) @(negedge clk);
        tach[ch] = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9 aborted run sets no done", res(ch), 32'h0);
        en[ch] = 1'b1;
        tach[ch] = 1'b0;
        repeat (6) @(negedge clk);
        tach[ch] = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9 re-enable does not restart", res(ch), 32'h0);
        trig[ch] = 1'b0; tach[ch] = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0F1A));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) chk("R1 reset value", res(c), 32'h0);

        do_measure(0, 0, 0, 20, 30);
        do_measure(1, 1, 1, 40, 25);
        do_measure(2, 0, 2, 37, 50);
        do_measure(3, 2, 3, 100, 90);
        do_measure(0, 3, 0, 300, 300);
        do_measure(1, 0, 0, 8, 8);
        do_measure(2, 1, 0, 5, 5);

        do_timeout(0, 0, 3, 1'b0);
        do_timeout(1, 1, 0, 1'b0);
        do_timeout(2, 0, 5, 1'b1);

        do_disable(3);

        for (int k = 0; k < 24; k++) begin
            int ch, d, md, hi, lo;
            ch = int'($urandom % NUM_CH);
            d  = int'($urandom % 2);
            md = int'($urandom % 3);
            hi = 8 + int'($urandom % 120);
            lo = 8 + int'($urandom % 120);
            do_measure(ch, d, md, hi, lo);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule